// File: doc/BRIEF.md
# Array Summation Controller-Datapath

This block adds up a fixed-length array of words held in an external memory. A start pulse makes it walk the array from a caller-supplied base address. It issues one read per element over a simple synchronous read port and keeps a running total. When every element has been added, it raises a completion flag and presents the total.

The design is split into two parts. An explicit state machine decides what happens in each cycle. A register datapath holds the running total, the element index and the current read address. Each of these three registers has a two-way input selector. The selector picks either the register's starting value or its updated value. The controller steps through five phases: setup, bound test, read, add and advance. This takes four cycles per element, which trades throughput for a small amount of hardware. The memory must return the addressed word one cycle after the read strobe.

Top module: `array_sum_unit`

## Requirements
- R1: While reset is active and after it is released, `done` and `mem_rd` are low, `sum` is zero and no read is issued until `start` is seen.
- R2: A `start` accepted from the idle or finished state clears the total and the index, and loads the read address from `base_addr`. `base_addr` is sampled only at that point.
- R3: Reads are issued at addresses `base_addr`, `base_addr+1`, … `base_addr+COUNT-1`, in that order, exactly once each. `COUNT` is 128 by default.
- R4: `mem_rd` is high for exactly one cycle per element. The word on `mem_rdata` in the cycle after the strobe is the one added to the total.
- R5: When the index is no longer below `COUNT`, `done` goes high. `sum` then equals the sum of the `COUNT` words read, and no read is issued while `done` is high.
- R6: `done` and `sum` stay unchanged for as long as `start` stays low in the finished state.
- R7: A `start` pulse or a change of `base_addr` while a summation is in progress has no effect on the result, the address order or the latency.
- R8: A `start` in the finished state drops `done` in the next cycle and runs a fresh summation from the new `base_addr`.
- R9: `done` rises exactly 4·COUNT+2 clock cycles after the edge that accepts `start`.
- R10: The total wraps modulo 2^DATA_W. With DATA_W=32 and all 128 words equal to 0xFFFFFFFF, the result is 0xFFFFFF80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a summation (accepted when idle or finished) |
| base_addr | input | ADDR_W | Address of the first array element |
| mem_addr | output | ADDR_W | Read address to the memory |
| mem_rd | output | 1 | Read strobe, one cycle per element |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the strobe |
| done | output | 1 | Summation complete; held until the next start |
| sum | output | DATA_W | Running total; the final result while done is high |

## Verification
A wrong state in the controller shows up at the ports within one element period (four cycles). It appears as a strobe lasting two cycles, a skipped or repeated address, or `done` rising at the wrong cycle count. A fault in the datapath selectors or adders shows up either in the address sequence at the next read or as a wrong total when `done` rises. Random array contents make an error in a single element visible in the result. The bench compares each read address as it is issued, as well as the final total and the exact latency, so a fault is tied to the cycle in which it first appears.

// File: rtl/asum_pkg.sv
package asum_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_TEST  = 3'd2,
    S_READ  = 3'd3,
    S_ADD   = 3'd4,
    S_STEP  = 3'd5,
    S_FIN   = 3'd6
  } asum_state_e;
endpackage

// File: rtl/asum_rst_sync.sv
module asum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/asum_mux_reg.sv
// Register with a two-way input selector: starting value or updated value.
module asum_mux_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sel_init,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb d = sel_init ? init_val : upd_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/asum_ctrl.sv
module asum_ctrl
  import asum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic more_left,
  output logic init,
  output logic acc_en,
  output logic step_en,
  output logic mem_rd,
  output logic done
);
  asum_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_SETUP;
      S_SETUP: state_d = S_TEST;
      S_TEST:  state_d = more_left ? S_READ : S_FIN;
      S_READ:  state_d = S_ADD;
      S_ADD:   state_d = S_STEP;
      S_STEP:  state_d = S_TEST;
      S_FIN:   if (start) state_d = S_SETUP;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    init    = (state_q == S_SETUP);
    mem_rd  = (state_q == S_READ);
    acc_en  = (state_q == S_ADD);
    step_en = (state_q == S_STEP);
    done    = (state_q == S_FIN);
  end
endmodule

// File: rtl/asum_datapath.sv
module asum_datapath #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int COUNT  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              acc_en,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              more_left,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] sum
);
  localparam int IDX_W = $clog2(COUNT + 1);

  logic [DATA_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  asum_mux_reg #(.W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(init | acc_en), .sel_init(init),
    .init_val('0), .upd_val(acc_q + mem_rdata), .q(acc_q)
  );

  asum_mux_reg #(.W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .en(init | step_en), .sel_init(init),
    .init_val('0), .upd_val(idx_q + IDX_W'(1)), .q(idx_q)
  );

  asum_mux_reg #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .en(init | step_en), .sel_init(init),
    .init_val(base_addr), .upd_val(addr_q + ADDR_W'(1)), .q(addr_q)
  );

  assign more_left = (idx_q < IDX_W'(COUNT));
  assign mem_addr  = addr_q;
  assign sum       = acc_q;
endmodule

// File: rtl/array_sum_unit.sv
module array_sum_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int COUNT  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] sum
);
  logic rst_int_n;
  logic init, acc_en, step_en, more_left;

  asum_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  asum_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .more_left(more_left),
    .init(init), .acc_en(acc_en), .step_en(step_en),
    .mem_rd(mem_rd), .done(done)
  );

  asum_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT(COUNT)) u_dp (
    .clk(clk), .rst_n(rst_int_n), .init(init), .acc_en(acc_en),
    .step_en(step_en), .base_addr(base_addr), .mem_rdata(mem_rdata),
    .more_left(more_left), .mem_addr(mem_addr), .sum(sum)
  );
endmodule

// File: rtl/array_sum_unit_chk.sv
module array_sum_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int COUNT  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              done,
  input logic [DATA_W-1:0] sum
);
  localparam int CNT_W = $clog2(COUNT + 1) + 1;

  logic [CNT_W-1:0]  rd_cnt;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt    <= '0;
      last_addr <= '0;
    end else if (done) begin
      rd_cnt    <= '0;
    end else if (mem_rd) begin
      rd_cnt    <= rd_cnt + CNT_W'(1);
      last_addr <= mem_addr;
    end
  end

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R4
  sum_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(sum));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && rd_cnt != '0) |-> mem_addr == last_addr + ADDR_W'(1));

  // R5
  no_rd_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);

  // R5
  rd_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> rd_cnt == CNT_W'(COUNT));

  // R6
  fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sum)));
endmodule

bind array_sum_unit array_sum_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT(COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .done(done), .sum(sum)
);

// File: tb/array_sum_unit_test.sv
`timescale 1ns/1ps
module array_sum_unit_test;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int COUNT  = 128;
  localparam int LAT    = 4 * COUNT + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd;
  logic [DATA_W-1:0] mem_rdata;
  logic              done;
  logic [DATA_W-1:0] sum;

  logic [DATA_W-1:0] mem [256];

  int total = 0;
  int bad = 0;
  int addr_bad = 0;
  int nrd = 0;
  int exp_addr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  array_sum_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT(COUNT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .done(done), .sum(sum)
  );

  // One-cycle synchronous memory model
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  // Read address monitor (R3)
  always @(negedge clk) begin
    if (rst_n && mem_rd) begin
      if (int'(mem_addr) != exp_addr) addr_bad++;
      exp_addr++;
      nrd++;
    end
  end

  function automatic logic [DATA_W-1:0] exp_sum(input int b);
    logic [DATA_W-1:0] s = '0;
    for (int i = 0; i < COUNT; i++) s = s + mem[(b + i) & 255];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int b, input bit noisy, input string tag);
    int cnt;
    logic [DATA_W-1:0] e;
    e = exp_sum(b);
    addr_bad = 0; nrd = 0; exp_addr = b;
    @(negedge clk);
    start = 1'b1; base_addr = ADDR_W'(b);
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    // R8: done drops in the cycle after start is accepted
    check(done == 1'b0, "R8", int'(done), 0);
    while (!done && cnt < LAT + 50) begin
      if (noisy && (cnt % 97 == 5)) begin
        start = 1'b1;
        base_addr = ADDR_W'((b + 40) & 127);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    // R9 (R7 when noisy): latency
    check(cnt - 1 == LAT, noisy ? "R7/R9 latency" : "R9 latency", cnt - 1, LAT);
    // R5 (R7 when noisy): result
    check(sum == e, noisy ? "R7/R5 sum" : "R5 sum", int'(sum), int'(e));
    // R3: address order
    check(addr_bad == 0, "R3 addr order", addr_bad, 0);
    check(nrd == COUNT, "R3 read count", nrd, COUNT);
    // R6: hold while start stays low
    repeat (7) @(negedge clk);
    check(done && sum == e, "R6 hold", int'(sum), int'(e));
    $display("run %s base=%0d sum=%0h", tag, b, sum);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    rst_n = 1'b0; start = 1'b0; base_addr = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(mem_rd == 1'b0, "R1 mem_rd", int'(mem_rd), 0);
    check(sum == '0, "R1 sum", int'(sum), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(done == 1'b0 && mem_rd == 1'b0 && nrd == 0, "R1 idle after release",
          int'(done), 0);
    // R2: first run from idle at base 0
    run(0, 1'b0, "R2 idle start");
    // R7: busy start pulses and base change
    run(int'($urandom_range(127)), 1'b1, "R7 noisy");
    // R8: restart from finished with a new base
    run(int'($urandom_range(127)), 1'b0, "R8 restart");
    // R10: wrap with all ones
    for (int i = 0; i < COUNT; i++) mem[(64 + i) & 255] = 32'hFFFF_FFFF;
    run(64, 1'b0, "R10 wrap");
    check(sum == 32'hFFFF_FF80, "R10 wrap value", int'(sum), 32'hFFFF_FF80);
    // zeros
    for (int i = 0; i < COUNT; i++) mem[i] = '0;
    run(0, 1'b0, "zeros");
    check(sum == '0, "R5 zero sum", int'(sum), 0);
    // highest base used, random data
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    run(127, 1'b0, "top base");
    run(int'($urandom_range(127)), 1'b1, "R7 noisy 2");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule